// File: doc/BRIEF.md
# DMA Controller Register and Interrupt Unit

This block is the register front end of a multi-channel DMA controller. A CPU reaches it over a simple valid/write bus addressed by 32-bit word within a 4 KB window. The block holds five words per channel: source address, destination address, linked-list pointer, control and configuration. It also holds one global configuration word. All of these are driven out as flat vectors to a separate channel engine, which moves the data.

The engine reports back with one-cycle pulses per channel: a terminal-count pulse when a transfer finishes and an error pulse when a transfer faults. Each pulse sets a sticky flag. Software clears flags by writing ones to them. Each channel enables its own interrupts through two bits of its configuration word, so there is no separate mask register. The block drives three levels from the enabled flags: a terminal-count interrupt, an error interrupt and their OR. The top of the window answers with eight identification bytes, and the first byte depends on the channel count.

Reads go through a two-state bus machine. It sits in `BUS_IDLE` until a read request arrives, then moves to `BUS_RESP` for the cycle in which the captured data is presented with `bus_rvalid`. A further read request in `BUS_RESP` keeps it there; anything else returns it to `BUS_IDLE`. Writes need no state and take effect at the clock edge that accepts them.

Top module: `dma_ctl_regs`

## Requirements
- R1: A write to word address 0x040 + 8·c + r (channel c, register r: 0 source, 1 destination, 2 link pointer, 3 control, 4 configuration) stores the data, and a read of the same address returns it; register codes 5 to 7 read 0.
- R2: With `NCH` = 2, channel indices 2 to 7 read 0, and writes to them change no register.
- R3: A pulse on `done_tc[c]` or `done_err[c]` sets sticky flag bit c. The raw flags read at word 5 (terminal count) and word 6 (error).
- R4: Writing word 2 (terminal count) or word 4 (error) clears every flag whose data bit is 1. A pulse in the same cycle as a clear of the same bit leaves the bit set.
- R5: Configuration bit 15 enables channel c's terminal-count interrupt and bit 14 enables its error interrupt. Word 1 reads the enabled terminal-count flags, word 3 reads the enabled error flags, and word 0 reads their OR.
- R6: `irq_tc` is high when any enabled terminal-count flag is set, `irq_err` is high when any enabled error flag is set, and `irq_any` is high when either is high.
- R7: Word 7 reads a bitmap whose bit c is bit 0 of channel c's configuration.
- R8: Word addresses 0x3F8 to 0x3FF read the bytes 80,10,04,0A,0D,F0,05,B1 (hex) in that order, with 81 as the first byte when `NCH` = 2.
- R9: Word 12 is a read/write global configuration word. Words 2, 4 and 8 to 11, the addresses 0x080 to 0x3F7, and the other global words all read 0. Writes to words 8 to 11 are ignored.
- R10: Reset clears all channel registers, the global configuration and all flags, and drops every interrupt line.
- R11: A read accepted at a clock edge is presented on `bus_rdata` with `bus_rvalid` high during the following cycle. `bus_rvalid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_waddr | input | 10 | Word address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| done_tc | input | NCH | Per-channel terminal-count pulse |
| done_err | input | NCH | Per-channel error pulse |
| chan_src | output | 32·NCH | Source address words, channel c at bits 32c upward |
| chan_dst | output | 32·NCH | Destination address words |
| chan_lli | output | 32·NCH | Linked-list pointer words |
| chan_ctrl | output | 32·NCH | Control words |
| chan_cfg | output | 32·NCH | Configuration words |
| glb_cfg | output | 32 | Global configuration word |
| irq_tc | output | 1 | Terminal-count interrupt |
| irq_err | output | 1 | Error interrupt |
| irq_any | output | 1 | Combined interrupt |

## Verification
- **Register contents:** a write or a pulse changes a register at the edge that accepts it, so a read request issued in the next cycle already sees the new value.
- **Read data:** it arrives one edge after the request.
- **Interrupt lines:** they are plain logic on registered flags and configuration, so they follow a pulse, a clear or a mask change one edge later.

The bench drives every input on the falling clock edge and samples every output on the next falling edge, which places each check inside the cycle where the result is due. A second instance built with two channels covers the out-of-range channel indices and the alternate identification byte.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;

    // register codes inside a channel bank
    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_LLI  = 3'd2;
    localparam logic [2:0] SEL_CTRL = 3'd3;
    localparam logic [2:0] SEL_CFG  = 3'd4;

    // global word indices
    localparam logic [5:0] GW_ALL     = 6'd0;
    localparam logic [5:0] GW_TC      = 6'd1;
    localparam logic [5:0] GW_TC_CLR  = 6'd2;
    localparam logic [5:0] GW_ERR     = 6'd3;
    localparam logic [5:0] GW_ERR_CLR = 6'd4;
    localparam logic [5:0] GW_RAW_TC  = 6'd5;
    localparam logic [5:0] GW_RAW_ERR = 6'd6;
    localparam logic [5:0] GW_EN_MAP  = 6'd7;
    localparam logic [5:0] GW_CFG     = 6'd12;

    // configuration word bit positions used by this unit
    localparam int CFG_EN_BIT    = 0;
    localparam int CFG_ERRIE_BIT = 14;
    localparam int CFG_TCIE_BIT  = 15;

    function automatic logic in_glb_win(input logic [9:0] a);
        return a[9:6] == 4'h0;
    endfunction

    function automatic logic in_chan_win(input logic [9:0] a);
        return a[9:6] == 4'h1;
    endfunction

    function automatic logic in_id_win(input logic [9:0] a);
        return a[9:3] == 7'h7F;
    endfunction

    function automatic logic [7:0] ident_byte(input logic [2:0] k, input logic two_ch);
        logic [7:0] b;
        case (k)
            3'd0: b = two_ch ? 8'h81 : 8'h80;
            3'd1: b = 8'h10;
            3'd2: b = 8'h04;
            3'd3: b = 8'h0A;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dma_ctl_bus_fsm.sv
module dma_ctl_bus_fsm
    import dma_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [9:0]  bus_waddr,
    input  logic [31:0] rd_value,
    output logic        ch_we,
    output logic [2:0]  ch_idx,
    output logic [2:0]  ch_sel,
    output logic        glb_we,
    output logic        tc_clr_we,
    output logic        err_clr_we,
    output logic        bus_rvalid,
    output logic [31:0] bus_rdata
);

    bus_state_e state_q, state_d;
    logic       rd_req, wr_req, glb_hit;

    assign rd_req  = bus_valid & ~bus_write;
    assign wr_req  = bus_valid &  bus_write;
    assign glb_hit = wr_req & in_glb_win(bus_waddr);

    // write decode
    always_comb begin
        ch_idx     = bus_waddr[5:3];
        ch_sel     = bus_waddr[2:0];
        ch_we      = wr_req & in_chan_win(bus_waddr);
        glb_we     = glb_hit & (bus_waddr[5:0] == GW_CFG);
        tc_clr_we  = glb_hit & (bus_waddr[5:0] == GW_TC_CLR);
        err_clr_we = glb_hit & (bus_waddr[5:0] == GW_ERR_CLR);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_req ? BUS_RESP : BUS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_req) bus_rdata <= rd_value;
    end

    always_comb begin
        unique case (state_q)
            BUS_IDLE: bus_rvalid = 1'b0;
            BUS_RESP: bus_rvalid = 1'b1;
        endcase
    end

    // R11: a read request is answered in the next cycle
    a_r11_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);
    // R11: no response without a request one cycle earlier
    a_r11_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(rd_req));

endmodule

// File: rtl/dma_ctl_chan_bank.sv
module dma_ctl_chan_bank
    import dma_ctl_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [2:0]      idx,
    input  logic [2:0]      sel,
    input  logic [31:0]     wdata,
    output logic [31:0]     rd_word,
    output logic [NCH*32-1:0] chan_src,
    output logic [NCH*32-1:0] chan_dst,
    output logic [NCH*32-1:0] chan_lli,
    output logic [NCH*32-1:0] chan_ctrl,
    output logic [NCH*32-1:0] chan_cfg
);

    localparam int IDX_W = $clog2(NCH);

    logic             idx_ok;
    logic [IDX_W-1:0] cidx;

    assign idx_ok = int'(idx) < NCH;
    assign cidx   = idx[IDX_W-1:0];

    logic [31:0] src_q  [NCH];
    logic [31:0] dst_q  [NCH];
    logic [31:0] lli_q  [NCH];
    logic [31:0] ctrl_q [NCH];
    logic [31:0] cfg_q  [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic hit;
        assign hit = we & idx_ok & (cidx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_q[g]  <= '0;
                dst_q[g]  <= '0;
                lli_q[g]  <= '0;
                ctrl_q[g] <= '0;
                cfg_q[g]  <= '0;
            end else if (hit) begin
                case (sel)
                    SEL_SRC:  src_q[g]  <= wdata;
                    SEL_DST:  dst_q[g]  <= wdata;
                    SEL_LLI:  lli_q[g]  <= wdata;
                    SEL_CTRL: ctrl_q[g] <= wdata;
                    SEL_CFG:  cfg_q[g]  <= wdata;
                    default: ;
                endcase
            end
        end

        assign chan_src [g*32 +: 32] = src_q[g];
        assign chan_dst [g*32 +: 32] = dst_q[g];
        assign chan_lli [g*32 +: 32] = lli_q[g];
        assign chan_ctrl[g*32 +: 32] = ctrl_q[g];
        assign chan_cfg [g*32 +: 32] = cfg_q[g];
    end

    always_comb begin
        rd_word = '0;
        if (idx_ok) begin
            case (sel)
                SEL_SRC:  rd_word = src_q[cidx];
                SEL_DST:  rd_word = dst_q[cidx];
                SEL_LLI:  rd_word = lli_q[cidx];
                SEL_CTRL: rd_word = ctrl_q[cidx];
                SEL_CFG:  rd_word = cfg_q[cidx];
                default:  rd_word = '0;
            endcase
        end
    end

    // R2: a write to a channel index beyond the count changes nothing
    a_r2_ignore_oob: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !idx_ok) |=> ($stable(chan_src) && $stable(chan_dst) && $stable(chan_lli)
                             && $stable(chan_ctrl) && $stable(chan_cfg)));

endmodule

// File: rtl/dma_ctl_irq.sv
module dma_ctl_irq #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] tc_set,
    input  logic [NCH-1:0] err_set,
    input  logic           tc_clr_we,
    input  logic           err_clr_we,
    input  logic [NCH-1:0] clr_bits,
    input  logic [NCH-1:0] tc_mask,
    input  logic [NCH-1:0] err_mask,
    output logic [NCH-1:0] tc_flag,
    output logic [NCH-1:0] err_flag,
    output logic [NCH-1:0] tc_act,
    output logic [NCH-1:0] err_act,
    output logic           irq_tc,
    output logic           irq_err,
    output logic           irq_any
);

    for (genvar g = 0; g < NCH; g++) begin : g_flag
        logic tc_kill, err_kill;
        assign tc_kill  = tc_clr_we  & clr_bits[g];
        assign err_kill = err_clr_we & clr_bits[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tc_flag[g]  <= 1'b0;
                err_flag[g] <= 1'b0;
            end else begin
                // a set in the same cycle overrides the clear
                tc_flag[g]  <= (tc_flag[g]  & ~tc_kill)  | tc_set[g];
                err_flag[g] <= (err_flag[g] & ~err_kill) | err_set[g];
            end
        end
    end

    assign tc_act  = tc_flag  & tc_mask;
    assign err_act = err_flag & err_mask;
    assign irq_tc  = |tc_act;
    assign irq_err = |err_act;
    assign irq_any = irq_tc | irq_err;

    // R3: every pulsed bit is set afterwards, R4: even when cleared in the same cycle
    a_r3_set_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_set != '0) |=> ((tc_flag & $past(tc_set)) == $past(tc_set)));
    a_r3_err_set_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set != '0) |=> ((err_flag & $past(err_set)) == $past(err_set)));
    // R4: cleared bits without a concurrent pulse are gone
    a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        tc_clr_we |=> ((tc_flag & $past(clr_bits) & ~$past(tc_set)) == '0));
    // R6: no raw flags means no interrupt
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_flag == '0 && err_flag == '0) |-> !irq_any);

endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
    import dma_ctl_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [9:0]        bus_waddr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    input  logic [NCH-1:0]    done_tc,
    input  logic [NCH-1:0]    done_err,
    output logic [NCH*32-1:0] chan_src,
    output logic [NCH*32-1:0] chan_dst,
    output logic [NCH*32-1:0] chan_lli,
    output logic [NCH*32-1:0] chan_ctrl,
    output logic [NCH*32-1:0] chan_cfg,
    output logic [31:0]       glb_cfg,
    output logic              irq_tc,
    output logic              irq_err,
    output logic              irq_any
);

    localparam logic TWO_CH = (NCH == 2);

    logic        ch_we, glb_we, tc_clr_we, err_clr_we;
    logic [2:0]  ch_idx, ch_sel;
    logic [31:0] rd_value, bank_word;
    logic [NCH-1:0] tc_mask, err_mask, en_map;
    logic [NCH-1:0] tc_flag, err_flag, tc_act, err_act;

    dma_ctl_bus_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_waddr  (bus_waddr),
        .rd_value   (rd_value),
        .ch_we      (ch_we),
        .ch_idx     (ch_idx),
        .ch_sel     (ch_sel),
        .glb_we     (glb_we),
        .tc_clr_we  (tc_clr_we),
        .err_clr_we (err_clr_we),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata)
    );

    dma_ctl_chan_bank #(.NCH(NCH)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (ch_we),
        .idx       (ch_idx),
        .sel       (ch_sel),
        .wdata     (bus_wdata),
        .rd_word   (bank_word),
        .chan_src  (chan_src),
        .chan_dst  (chan_dst),
        .chan_lli  (chan_lli),
        .chan_ctrl (chan_ctrl),
        .chan_cfg  (chan_cfg)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_cfg_bits
        assign tc_mask[g]  = chan_cfg[g*32 + CFG_TCIE_BIT];
        assign err_mask[g] = chan_cfg[g*32 + CFG_ERRIE_BIT];
        assign en_map[g]   = chan_cfg[g*32 + CFG_EN_BIT];
    end

    dma_ctl_irq #(.NCH(NCH)) i_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tc_set     (done_tc),
        .err_set    (done_err),
        .tc_clr_we  (tc_clr_we),
        .err_clr_we (err_clr_we),
        .clr_bits   (bus_wdata[NCH-1:0]),
        .tc_mask    (tc_mask),
        .err_mask   (err_mask),
        .tc_flag    (tc_flag),
        .err_flag   (err_flag),
        .tc_act     (tc_act),
        .err_act    (err_act),
        .irq_tc     (irq_tc),
        .irq_err    (irq_err),
        .irq_any    (irq_any)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      glb_cfg <= '0;
        else if (glb_we) glb_cfg <= bus_wdata;
    end

    // read multiplexer
    always_comb begin
        rd_value = '0;
        if (in_chan_win(bus_waddr)) begin
            rd_value = bank_word;
        end else if (in_id_win(bus_waddr)) begin
            rd_value = {24'h0, ident_byte(bus_waddr[2:0], TWO_CH)};
        end else if (in_glb_win(bus_waddr)) begin
            case (bus_waddr[5:0])
                GW_ALL:     rd_value = 32'(tc_act | err_act);
                GW_TC:      rd_value = 32'(tc_act);
                GW_ERR:     rd_value = 32'(err_act);
                GW_RAW_TC:  rd_value = 32'(tc_flag);
                GW_RAW_ERR: rd_value = 32'(err_flag);
                GW_EN_MAP:  rd_value = 32'(en_map);
                GW_CFG:     rd_value = glb_cfg;
                default:    rd_value = '0;
            endcase
        end
    end

    // R6: an interrupt line rises only if a flag was pulsed or a mask was written
    a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_any) |-> ($past(done_tc != '0) || $past(done_err != '0) || $past(ch_we)));

endmodule

// File: tb/test_dma_ctl_regs.sv
module test_dma_ctl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [9:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [7:0]  done_tc = '0, done_err = '0;

    logic        rv8, rv2;
    logic [31:0] rd8, rd2, g8, g2;
    logic        it8, ie8, ia8, it2, ie2, ia2;
    logic [255:0] s8, d8, l8, c8, f8;
    logic [63:0]  s2, d2, l2, c2, f2;

    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    dma_ctl_regs #(.NCH(8)) i_dma_ctl_regs (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rvalid(rv8), .bus_rdata(rd8),
        .done_tc(done_tc), .done_err(done_err), .chan_src(s8), .chan_dst(d8),
        .chan_lli(l8), .chan_ctrl(c8), .chan_cfg(f8), .glb_cfg(g8),
        .irq_tc(it8), .irq_err(ie8), .irq_any(ia8));

    dma_ctl_regs #(.NCH(2)) i_dma_ctl_regs_two (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rvalid(rv2), .bus_rdata(rd2),
        .done_tc(done_tc[1:0]), .done_err(done_err[1:0]), .chan_src(s2), .chan_dst(d2),
        .chan_lli(l2), .chan_ctrl(c2), .chan_cfg(f2), .glb_cfg(g2),
        .irq_tc(it2), .irq_err(ie2), .irq_any(ia2));

    typedef struct packed {
        logic        wr;
        logic [9:0]  a;
        logic [31:0] d;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 10'h040, 32'hA5A5_0001, 4'd1},   // R1 ch0 source
        '{1'b0, 10'h040, 32'hA5A5_0001, 4'd1},
        '{1'b1, 10'h07B, 32'h1234_5678, 4'd1},   // R1 ch7 control
        '{1'b0, 10'h07B, 32'h1234_5678, 4'd1},
        '{1'b1, 10'h05A, 32'hDEAD_BEEF, 4'd1},   // R1 ch3 link pointer
        '{1'b0, 10'h05A, 32'hDEAD_BEEF, 4'd1},
        '{1'b1, 10'h051, 32'h0000_F00D, 4'd1},   // R1 ch2 destination
        '{1'b0, 10'h051, 32'h0000_F00D, 4'd1},
        '{1'b0, 10'h045, 32'h0,         4'd1},   // R1 register code 5 reads 0
        '{1'b1, 10'h00C, 32'h0000_0001, 4'd9},   // R9 global configuration
        '{1'b0, 10'h00C, 32'h0000_0001, 4'd9},
        '{1'b1, 10'h008, 32'hFFFF_FFFF, 4'd9},   // R9 request word ignored
        '{1'b0, 10'h008, 32'h0,         4'd9},
        '{1'b0, 10'h100, 32'h0,         4'd9},   // R9 unmapped gap
        '{1'b0, 10'h3F8, 32'h80,        4'd8},   // R8 identification
        '{1'b0, 10'h3FB, 32'h0A,        4'd8},
        '{1'b0, 10'h3FF, 32'hB1,        4'd8},
        '{1'b1, 10'h04C, 32'h0000_C001, 4'd7},   // R7 ch1 enabled, both irq enables
        '{1'b0, 10'h007, 32'h0000_0002, 4'd7},
        '{1'b0, 10'h004, 32'h0,         4'd9},   // R9 clear word reads 0
        '{1'b1, 10'h064, 32'h0000_0001, 4'd7},   // R7 ch4 enabled
        '{1'b0, 10'h007, 32'h0000_0012, 4'd7}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_waddr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic do_read(input logic [9:0] a, output logic [31:0] v8,
                           output logic [31:0] v2, output logic ok);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_waddr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        v8 = rd8; v2 = rd2; ok = rv8;
    endtask

    task automatic pulse(input logic [7:0] tc, input logic [7:0] er);
        @(negedge clk);
        done_tc = tc; done_err = er;
        @(negedge clk);
        done_tc = '0; done_err = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v8, v2;
        logic ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        chk("R10 irq_any after reset", 32'(ia8), 32'h0);
        chk("R11 rvalid idle", 32'(rv8), 32'h0);
        do_read(10'h040, v8, v2, ok);
        chk("R10 ch0 source after reset", v8, 32'h0);
        chk("R11 rvalid on response", 32'(ok), 32'h1);
        @(negedge clk);
        chk("R11 rvalid drops", 32'(rv8), 32'h0);

        // stimulus table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                do_write(VEC[i].a, VEC[i].d);
            end else begin
                do_read(VEC[i].a, v8, v2, ok);
                chk($sformatf("R%0d vector %0d", VEC[i].req, i), v8, VEC[i].d);
            end
        end

        // R3 R5 R6 terminal-count pulses on ch1 (enabled) and ch5 (not enabled)
        pulse(8'h22, 8'h00);
        chk("R6 irq_tc", 32'(it8), 32'h1);
        chk("R6 irq_err", 32'(ie8), 32'h0);
        chk("R6 irq_any", 32'(ia8), 32'h1);
        do_read(10'h005, v8, v2, ok); chk("R3 raw tc", v8, 32'h22);
        do_read(10'h001, v8, v2, ok); chk("R5 masked tc", v8, 32'h02);
        do_read(10'h000, v8, v2, ok); chk("R5 combined", v8, 32'h02);

        pulse(8'h00, 8'h22);
        chk("R6 irq_err set", 32'(ie8), 32'h1);
        do_read(10'h006, v8, v2, ok); chk("R3 raw err", v8, 32'h22);
        do_read(10'h003, v8, v2, ok); chk("R5 masked err", v8, 32'h02);

        // R4 write-one-to-clear
        do_write(10'h002, 32'h0000_0002);
        chk("R6 irq_tc after clear", 32'(it8), 32'h0);
        do_read(10'h005, v8, v2, ok); chk("R4 tc clear", v8, 32'h20);
        do_write(10'h004, 32'h0000_0020);
        do_read(10'h006, v8, v2, ok); chk("R4 err clear", v8, 32'h02);

        // R4 pulse and clear of the same bit in one cycle
        @(negedge clk);
        done_tc = 8'h02;
        bus_valid = 1'b1; bus_write = 1'b1; bus_waddr = 10'h002; bus_wdata = 32'h2;
        @(negedge clk);
        done_tc = '0; bus_valid = 1'b0; bus_write = 1'b0;
        do_read(10'h005, v8, v2, ok); chk("R4 set beats clear", v8, 32'h22);

        // R5 disabling the terminal-count enable of ch1
        do_write(10'h04C, 32'h0000_4001);
        chk("R5 irq_tc masked off", 32'(it8), 32'h0);
        chk("R5 irq_err still on", 32'(ie8), 32'h1);
        do_read(10'h001, v8, v2, ok); chk("R5 masked tc off", v8, 32'h0);

        // R2 two-channel build
        do_read(10'h05A, v8, v2, ok);
        chk("R2 ch3 absent in two-channel build", v2, 32'h0);
        chk("R1 ch3 present in eight-channel build", v8, 32'hDEAD_BEEF);
        do_read(10'h040, v8, v2, ok); chk("R2 ch0 present", v2, 32'hA5A5_0001);
        do_read(10'h007, v8, v2, ok); chk("R2 bitmap ignores ch4", v2, 32'h02);
        do_read(10'h3F8, v8, v2, ok); chk("R8 two-channel identification", v2, 32'h81);

        // R10 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 irq lines cleared", {29'h0, it8, ie8, ia8}, 32'h0);
        rst_n = 1'b1;
        do_read(10'h040, v8, v2, ok); chk("R10 channel reg cleared", v8, 32'h0);
        do_read(10'h005, v8, v2, ok); chk("R10 flags cleared", v8, 32'h0);
        do_read(10'h00C, v8, v2, ok); chk("R10 global cfg cleared", v8, 32'h0);
        do_read(10'h007, v8, v2, ok); chk("R10 bitmap cleared", v8, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule